// File: doc/BRIEF.md
# Two-Bank Pulse Record Buffer

This block sits between a pulse acquisition front end and a host processor. The acquisition side pushes record words one at a time: time stamps, widths, amplitudes or waveform samples, and side words such as bearing or carrier frequency. It also marks the last word of each record. A block-end strobe closes the current group of records. When a block closes, the block stores a header with the record count and the capture mode, hands the whole bank to the host, and moves the writer to the other bank.

The two banks swap roles only at block boundaries. The writer moves into the other bank only if the host has released it. If the host has not, the writer is told to stall until the host releases that bank. The host drains a ready bank one word per request, header first. A fill count tells the host how many words the bank holds, including a short final block, and a release strobe gives the bank back to the writer. Blocks reach the host in the order they were closed.

Top module: `pp_rec_buffer`

## Requirements
- R1: After reset, `acq_stall`, `host_ready`, `host_valid` are 0, and `acq_fill` and `host_fill` are 0.
- R2: Payload words accepted into a block are returned to the host in the order they were written, after the header word. `host_data` is valid in the cycle after the `host_rd` request that fetched it.
- R3: The header word is the first word the host reads from a block. Bit 15 holds the mode (0 = single amplitude, 1 = waveform), sampled from `acq_mode` with `acq_blk_end`. Bits 14:0 hold the number of accepted words flagged with `acq_last` in that block, including a word accepted in the same cycle as `acq_blk_end`.
- R4: When a block is closed and the other bank is not held by the host, the writer moves on at once and `acq_stall` stays 0.
- R5: When a block is closed while the other bank is still held by the host, `acq_stall` rises in the next cycle. Record words offered while stalled are discarded. `acq_stall` is 0 again two cycles after the host releases that bank.
- R6: A bank holds DEPTH-1 payload words. Once that many are accepted, `acq_stall` is 1 and further words are discarded until block end.
- R7: After a block is closed, `host_ready` is 1 and `host_fill` equals its payload word count plus one.
- R8: `host_valid` rises only for a request made while a block is ready and words remain unread. Requests beyond `host_fill` produce no `host_valid`.
- R9: `host_release` while no block is ready has no effect on which bank the host reads next.
- R10: The writer never writes a bank the host holds, and closed blocks reach the host in closing order.
- R11: `acq_fill` counts payload words accepted into the open block, and returns to 0 when a block closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acq_valid | input | 1 | Record word offered |
| acq_last | input | 1 | Offered word ends a record |
| acq_data | input | 16 | Record word |
| acq_mode | input | 1 | Mode code, sampled at block end |
| acq_blk_end | input | 1 | Close the open block |
| acq_stall | output | 1 | Writer must hold off |
| acq_fill | output | 5 | Payload words in the open block |
| host_rd | input | 1 | Fetch next word of the ready block |
| host_release | input | 1 | Hand the ready bank back |
| host_ready | output | 1 | A closed block is available |
| host_fill | output | 5 | Words in the ready block, header included |
| host_valid | output | 1 | host_data carries a fetched word |
| host_data | output | 16 | Fetched word |

## Verification
The hardest state to reach is a writer waiting on a bank the host still holds. Reaching it takes two closed blocks that the host has not yet drained. The bench closes one block and leaves it unread, then fills and closes a second while the first is still ready. This holds the stall open. It offers a stray word during the stall, releases the first bank, and confirms that the stray word never shows up in the next block the host reads. A full bank and a release sent while nothing is ready are driven through the same ports.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int PP_DW = 16;

    typedef enum logic {
        MODE_AMPL = 1'b0,
        MODE_WAVE = 1'b1
    } pp_mode_e;

    typedef struct packed {
        pp_mode_e               mode;
        logic [PP_DW-2:0]       count;
    } pp_hdr_t;

    function automatic pp_hdr_t make_hdr(pp_mode_e m, logic [PP_DW-2:0] n);
        pp_hdr_t h;
        h.mode  = m;
        h.count = n;
        return h;
    endfunction

endpackage

// File: rtl/pp_bank.sv
module pp_bank
    import pp_pkg::*;
#(
    parameter int PAY = 15,
    parameter int AW  = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PP_DW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PP_DW-1:0] rdata
);

    logic [PP_DW-1:0] mem [PAY];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
    import pp_pkg::*;
#(
    parameter int PAY = 15,
    parameter int FW  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          wr_last,
    input  pp_mode_e      wr_mode,
    input  logic          blk_end,
    input  logic [1:0]    bank_ready,
    output logic          stall,
    output logic          wbank,
    output logic [FW-1:0] wptr,
    output logic          we,
    output logic          seal,
    output pp_hdr_t       seal_hdr,
    output logic [FW-1:0] seal_fill
);

    logic          waiting;
    logic [FW-1:0] rcnt;
    logic [FW-1:0] rcnt_nxt;
    logic          full;
    logic          accept;
    logic          other_ready;

    always_comb begin
        other_ready = bank_ready[wbank ^ 1'b1];
        full        = (wptr == FW'(PAY));
        accept      = wr_valid && !waiting && !full;
        we          = accept;
        rcnt_nxt    = rcnt + FW'(accept && wr_last);
        seal        = blk_end && !waiting;
        seal_hdr    = make_hdr(wr_mode, (PP_DW-1)'(rcnt_nxt));
        seal_fill   = wptr + FW'(accept);
        stall       = waiting || full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbank   <= 1'b0;
            waiting <= 1'b0;
            wptr    <= '0;
            rcnt    <= '0;
        end else if (waiting) begin
            if (!other_ready) begin
                wbank   <= ~wbank;
                waiting <= 1'b0;
                wptr    <= '0;
                rcnt    <= '0;
            end
        end else if (seal) begin
            if (other_ready) begin
                waiting <= 1'b1;
            end else begin
                wbank <= ~wbank;
            end
            wptr <= '0;
            rcnt <= '0;
        end else if (accept) begin
            wptr <= wptr + 1'b1;
            rcnt <= rcnt_nxt;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        wptr <= FW'(PAY)); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && !seal) |=> $stable(wptr)); // R6
    AST_WAIT_STALL: assert property (@(posedge clk) disable iff (rst)
        (seal && other_ready) |=> stall); // R5
    AST_SWAP_FILL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wbank != $past(wbank)) |-> (wptr == '0)); // R11

endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
    import pp_pkg::*;
#(
    parameter int PAY = 15,
    parameter int FW  = 5,
    parameter int AW  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  seal,
    input  logic                  wbank,
    input  pp_hdr_t               seal_hdr,
    input  logic [FW-1:0]         seal_fill,
    input  logic                  rd_en,
    input  logic                  host_release,
    input  logic [1:0][PP_DW-1:0] bank_q,
    output logic [1:0]            bank_ready,
    output logic                  hbank,
    output logic [AW-1:0]         raddr,
    output logic                  rd_ready,
    output logic [FW-1:0]         rd_fill,
    output logic                  rd_valid,
    output logic [PP_DW-1:0]      rd_data
);

    logic [1:0]          ready_q;
    pp_hdr_t [1:0]       hdr_q;
    logic [1:0][FW-1:0]  fill_q;
    logic [FW-1:0]       rptr;
    logic                pend;
    logic                was_hdr;
    logic                rbank;
    logic                fire;
    logic                rel;

    always_comb begin
        bank_ready = ready_q;
        rd_ready   = ready_q[hbank];
        rd_fill    = rd_ready ? (fill_q[hbank] + 1'b1) : '0;
        fire       = rd_en && rd_ready && (rptr <= fill_q[hbank]);
        rel        = host_release && rd_ready;
        raddr      = (rptr == '0) ? '0 : AW'(rptr - 1'b1);
        rd_valid   = pend;
        rd_data    = was_hdr ? PP_DW'(hdr_q[rbank]) : bank_q[rbank];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= '0;
            hdr_q   <= '0;
            fill_q  <= '0;
            hbank   <= 1'b0;
            rptr    <= '0;
            pend    <= 1'b0;
            was_hdr <= 1'b0;
            rbank   <= 1'b0;
        end else begin
            pend <= fire;
            if (fire) begin
                rptr    <= rptr + 1'b1;
                was_hdr <= (rptr == '0);
                rbank   <= hbank;
            end
            if (seal) begin
                ready_q[wbank] <= 1'b1;
                hdr_q[wbank]   <= seal_hdr;
                fill_q[wbank]  <= seal_fill;
            end
            if (rel) begin
                ready_q[hbank] <= 1'b0;
                hbank          <= ~hbank;
                rptr           <= '0;
            end
        end
    end

    AST_RD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_ready)); // R8
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (host_release && !rd_ready) |=> $stable(hbank)); // R9
    AST_SEAL_READY: assert property (@(posedge clk) disable iff (rst)
        seal |=> bank_ready[$past(wbank)]); // R7

endmodule

// File: rtl/pp_rec_buffer.sv
module pp_rec_buffer
    import pp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PAY = DEPTH - 1,
    localparam int AW  = (PAY > 1) ? $clog2(PAY) : 1,
    localparam int FW  = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_valid,
    input  logic             acq_last,
    input  logic [PP_DW-1:0] acq_data,
    input  logic             acq_mode,
    input  logic             acq_blk_end,
    output logic             acq_stall,
    output logic [FW-1:0]    acq_fill,
    input  logic             host_rd,
    input  logic             host_release,
    output logic             host_ready,
    output logic [FW-1:0]    host_fill,
    output logic             host_valid,
    output logic [PP_DW-1:0] host_data
);

    logic                  wbank;
    logic                  hbank;
    logic [FW-1:0]         wptr;
    logic                  we;
    logic                  seal;
    pp_hdr_t               seal_hdr;
    logic [FW-1:0]         seal_fill;
    logic [1:0]            bank_ready;
    logic [AW-1:0]         raddr;
    logic [1:0][PP_DW-1:0] bank_q;

    pp_wr_ctrl #(.PAY(PAY), .FW(FW)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (acq_valid),
        .wr_last    (acq_last),
        .wr_mode    (pp_mode_e'(acq_mode)),
        .blk_end    (acq_blk_end),
        .bank_ready (bank_ready),
        .stall      (acq_stall),
        .wbank      (wbank),
        .wptr       (wptr),
        .we         (we),
        .seal       (seal),
        .seal_hdr   (seal_hdr),
        .seal_fill  (seal_fill)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_bank
            pp_bank #(.PAY(PAY), .AW(AW)) u_bank (
                .clk   (clk),
                .we    (we && (wbank == 1'(g))),
                .waddr (AW'(wptr)),
                .wdata (acq_data),
                .raddr (raddr),
                .rdata (bank_q[g])
            );
        end
    endgenerate

    pp_rd_ctrl #(.PAY(PAY), .FW(FW), .AW(AW)) u_rd (
        .clk          (clk),
        .rst          (rst),
        .seal         (seal),
        .wbank        (wbank),
        .seal_hdr     (seal_hdr),
        .seal_fill    (seal_fill),
        .rd_en        (host_rd),
        .host_release (host_release),
        .bank_q       (bank_q),
        .bank_ready   (bank_ready),
        .hbank        (hbank),
        .raddr        (raddr),
        .rd_ready     (host_ready),
        .rd_fill      (host_fill),
        .rd_valid     (host_valid),
        .rd_data      (host_data)
    );

    assign acq_fill = wptr;

    AST_NO_SHARED_BANK: assert property (@(posedge clk) disable iff (rst)
        we |-> !bank_ready[wbank]); // R10
    AST_HOST_OTHER_BANK: assert property (@(posedge clk) disable iff (rst)
        (we && host_ready) |-> (hbank != wbank)); // R10

endmodule

// File: tb/sim_pp_rec_buffer.sv
`timescale 1ns/1ps
module sim_pp_rec_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_valid = 1'b0, acq_last = 1'b0, acq_mode = 1'b0, acq_blk_end = 1'b0;
    logic [15:0] acq_data = '0;
    logic        acq_stall;
    logic [4:0]  acq_fill;
    logic        host_rd = 1'b0, host_release = 1'b0;
    logic        host_ready, host_valid;
    logic [4:0]  host_fill;
    logic [15:0] host_data;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] exp_w [0:31];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pp_rec_buffer #(.DEPTH(16)) u0 (
        .clk(clk), .rst(rst),
        .acq_valid(acq_valid), .acq_last(acq_last), .acq_data(acq_data),
        .acq_mode(acq_mode), .acq_blk_end(acq_blk_end),
        .acq_stall(acq_stall), .acq_fill(acq_fill),
        .host_rd(host_rd), .host_release(host_release),
        .host_ready(host_ready), .host_fill(host_fill),
        .host_valid(host_valid), .host_data(host_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] d, logic l);
        acq_valid = 1'b1; acq_data = d; acq_last = l;
        @(negedge clk);
        acq_valid = 1'b0; acq_last = 1'b0;
    endtask

    task automatic seal(logic m);
        acq_blk_end = 1'b1; acq_mode = m;
        @(negedge clk);
        acq_blk_end = 1'b0;
    endtask

    task automatic wr_seal(logic [15:0] d, logic l, logic m);
        acq_valid = 1'b1; acq_data = d; acq_last = l;
        acq_blk_end = 1'b1; acq_mode = m;
        @(negedge clk);
        acq_valid = 1'b0; acq_last = 1'b0; acq_blk_end = 1'b0;
    endtask

    task automatic release_bank();
        host_release = 1'b1;
        @(negedge clk);
        host_release = 1'b0;
    endtask

    task automatic read_block(string req, int n);
        check({req, " ready"}, 32'(host_ready), 32'd1);
        check({req, " R7 fill"}, 32'(host_fill), 32'(n));
        for (int i = 0; i < n; i++) begin
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
            check({req, " valid"}, 32'(host_valid), 32'd1);
            check({req, (i == 0) ? " R3 header" : " R2 word"}, 32'(host_data), 32'(exp_w[i]));
        end
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check({req, " R8 over-read"}, 32'(host_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 stall", 32'(acq_stall), 32'd0);
        check("R1 ready", 32'(host_ready), 32'd0);
        check("R1 valid", 32'(host_valid), 32'd0);
        check("R1 acq_fill", 32'(acq_fill), 32'd0);
        check("R1 host_fill", 32'(host_fill), 32'd0);
    endtask

    task automatic t_basic();
        wr(16'h1111, 1'b0); wr(16'h1112, 1'b1);
        wr(16'h2221, 1'b0); wr(16'h2222, 1'b0); wr(16'h2223, 1'b1);
        check("R11 fill count", 32'(acq_fill), 32'd5);
        seal(1'b0);
        check("R4 no stall", 32'(acq_stall), 32'd0);
        check("R11 fill cleared", 32'(acq_fill), 32'd0);
        exp_w[0] = 16'h0002; exp_w[1] = 16'h1111; exp_w[2] = 16'h1112;
        exp_w[3] = 16'h2221; exp_w[4] = 16'h2222; exp_w[5] = 16'h2223;
        read_block("R2 basic", 6);
        release_bank();
        check("R7 released", 32'(host_ready), 32'd0);
    endtask

    task automatic t_wait();
        wr(16'h3331, 1'b1); wr(16'h3332, 1'b0);
        wr_seal(16'h3333, 1'b1, 1'b1);
        check("R4 swap free", 32'(acq_stall), 32'd0);
        wr(16'h4441, 1'b1);
        seal(1'b0);
        check("R5 stall", 32'(acq_stall), 32'd1);
        wr(16'hDEAD, 1'b1);
        check("R5 still stall", 32'(acq_stall), 32'd1);
        exp_w[0] = 16'h8002; exp_w[1] = 16'h3331; exp_w[2] = 16'h3332; exp_w[3] = 16'h3333;
        read_block("R10 first block", 4);
        release_bank();
        @(negedge clk);
        check("R5 stall drops", 32'(acq_stall), 32'd0);
        exp_w[0] = 16'h0001; exp_w[1] = 16'h4441;
        read_block("R5 R10 second block", 2);
        release_bank();
    endtask

    task automatic t_full();
        for (int i = 0; i < 15; i++) wr(16'h6000 + 16'(i), 1'b1);
        check("R6 stall full", 32'(acq_stall), 32'd1);
        check("R6 fill", 32'(acq_fill), 32'd15);
        wr(16'hBEEF, 1'b1); wr(16'hBEEF, 1'b1);
        seal(1'b1);
        check("R4 stall after seal", 32'(acq_stall), 32'd0);
        exp_w[0] = 16'h800F;
        for (int i = 0; i < 15; i++) exp_w[i + 1] = 16'h6000 + 16'(i);
        read_block("R6 full block", 16);
        release_bank();
    endtask

    task automatic t_idle_release();
        release_bank();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R8 read idle", 32'(host_valid), 32'd0);
        wr(16'h5555, 1'b1);
        seal(1'b0);
        exp_w[0] = 16'h0001; exp_w[1] = 16'h5555;
        read_block("R9 order kept", 2);
        release_bank();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wait();
        t_full();
        t_idle_release();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule